// File: doc/BRIEF.md
# PLL Control Register Bank with Masked Writes

This block is a small register file that holds the control settings of four phase-locked loops, plus one mode register that all four share. Software reaches it over a plain 32-bit bus. Each access carries a byte address, write data and a write strobe. Read data comes back combinationally from the address. Every write carries its own bit-enable mask in the upper half-word. A bit in the lower half changes only when its enable bit is set, so one field can be updated without first reading the word back.

For each loop the bank decodes and drives the following:

- the reference-divider, output-divider and feedback-multiplier fields;
- the bandwidth-adjust field;
- the operating mode;
- the bypass, power-down, standby and reset controls.

The divider and multiplier fields are held as (value − 1). The bank also computes two things for each loop. The first is a "running normally" flag. The second is an effective output rate, derived from a parent-rate input. The rate uses the decoded values and falls back to the parent rate whenever the loop is not running normally.

Top module: `pll_ctrl_bank`

## Requirements
- R1: A write updates bit k (0..15) of the addressed word only when data bit k+16 is 1. Bits whose enable is 0 keep their old value. A write with an all-zero upper half changes nothing.
- R2: Loop n (0..3) owns four words at byte address n*16 + i*4, for i = 0..3. The shared mode register is at byte address 64.
- R3: A read of a mapped address returns the stored 16-bit word in bits 15:0, with bits 31:16 equal to zero.
- R4: A read of any other address returns zero, including addresses 64..255 other than 64 and addresses with bits 1:0 not both zero. A write to such an address changes no stored word.
- R5: After reset every word reads zero, except word 3 of each loop, which reads 0x0001 (bypass set). All modes are slow (0).
- R6: Word 0 drives the output-divider field from bits 5:0 and the reference-divider field from bits 13:8.
- R7: Word 1 drives the feedback-multiplier field from bits 15:0. Word 2 drives the bandwidth-adjust field from bits 11:0.
- R8: Word 3 drives the controls as follows, each active when the bit is 1: bypass from bit 0, power-down from bit 1, standby from bit 2, reset from bit 5.
- R9: Loop n's mode output is mode-register bits n*4+1 : n*4. The encoding is 0 slow, 1 normal, 2 deep slow.
- R10: A loop's normal flag is 1 exactly when its mode is 1 and its bypass bit is 0.
- R11: While a loop's normal flag is 1, its rate output equals floor(floor(parent × (F+1) / (R+1)) / (O+1)), where F, R and O are the stored feedback, reference and output fields. The product is formed at 64 bits.
- R12: While a loop's normal flag is 0, its rate output equals the parent rate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busAddr | input | 8 | Byte address of the access |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 32 | Bits 31:16 are the bit enables; bits 15:0 are the data |
| busRdData | output | 32 | Read data for busAddr |
| parentRate | input | 32 | Input reference rate |
| pllRefDiv | output | 4 x 6 | Stored reference-divider field per loop |
| pllOutDiv | output | 4 x 6 | Stored output-divider field per loop |
| pllFbMul | output | 4 x 16 | Stored feedback-multiplier field per loop |
| pllBwAdj | output | 4 x 12 | Bandwidth-adjust field per loop |
| pllMode | output | 4 x 2 | Mode per loop |
| pllBypass | output | 4 | Bypass per loop |
| pllPowerDown | output | 4 | Power-down per loop |
| pllStandby | output | 4 | Standby per loop |
| pllReset | output | 4 | Reset per loop |
| pllNormal | output | 4 | Running-normally flag per loop |
| pllRate | output | 4 x 48 | Effective output rate per loop |

## Verification
Stored words come back to the ports within one cycle, both as read data and as the decoded fields. A wrong bit left by a masked write therefore shows on the next read of that word, and at once on the field or control output it feeds. A misdecoded address either corrupts a neighbouring word or leaves the target unchanged. That is visible on the next full sweep of reads, which follows every write. Errors in the mode or bypass decode show up as a wrong normal flag, and so as a rate that fails to fall back to the parent, in the same cycle as the write.

// File: rtl/pll_bank_pkg.sv
package pll_bank_pkg;

  localparam int PLL_COUNT     = 4;
  localparam int PLL_IDX_W     = 2;
  localparam int WORDS_PER_PLL = 4;
  localparam int WORD_IDX_W    = 2;
  localparam int HALF_W        = 16;
  localparam int BUS_W         = 2 * HALF_W;
  localparam int DIV_W         = 6;
  localparam int FB_W          = 16;
  localparam int BW_W          = 12;
  localparam int MODE_FLD_W    = 2;
  localparam int MODE_STRIDE   = 4;
  localparam int PLL_STRIDE    = 16;
  localparam int MODE_OFFSET   = PLL_COUNT * PLL_STRIDE;
  localparam int CALC_W        = 64;

  // bit positions inside the control words
  localparam int OD_LSB   = 0;
  localparam int REF_LSB  = 8;
  localparam int BYP_BIT  = 0;
  localparam int PD_BIT   = 1;
  localparam int SB_BIT   = 2;
  localparam int RST_BIT  = 5;

  localparam logic [HALF_W-1:0] CTL_WORD_RESET = 16'h0001;

  typedef enum logic [MODE_FLD_W-1:0] {
    MODE_SLOW   = 2'd0,
    MODE_NORMAL = 2'd1,
    MODE_DEEP   = 2'd2
  } pllMode_e;

  // strobes from the address decoder to the storage datapath
  typedef struct packed {
    logic                  wrStb;
    logic                  conHit;
    logic                  modeHit;
    logic [PLL_IDX_W-1:0]  pllSel;
    logic [WORD_IDX_W-1:0] wordSel;
  } bankStrobe_t;

  function automatic logic [HALF_W-1:0] maskMerge(input logic [HALF_W-1:0] cur,
                                                  input logic [BUS_W-1:0]  wd);
    logic [HALF_W-1:0] en;
    en = wd[BUS_W-1:HALF_W];
    return (cur & ~en) | (wd[HALF_W-1:0] & en);
  endfunction

endpackage

// File: rtl/pll_bank_decode.sv
module pll_bank_decode
  import pll_bank_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output bankStrobe_t       stb
);

  localparam int WORD_LSB = 2;
  localparam int PLL_LSB  = WORD_LSB + WORD_IDX_W;

  logic aligned;
  assign aligned = (busAddr[WORD_LSB-1:0] == '0);

  always_comb begin
    stb         = '0;
    stb.wrStb   = busWrEn;
    stb.wordSel = busAddr[WORD_LSB +: WORD_IDX_W];
    stb.pllSel  = busAddr[PLL_LSB +: PLL_IDX_W];
    if (aligned) begin
      if (busAddr < ADDR_W'(MODE_OFFSET)) begin
        stb.conHit = 1'b1;
      end else if (busAddr == ADDR_W'(MODE_OFFSET)) begin
        stb.modeHit = 1'b1;
      end
    end
  end

endmodule

// File: rtl/pll_bank_regs.sv
module pll_bank_regs
  import pll_bank_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  bankStrobe_t stb,
  input  logic [BUS_W-1:0] busWrData,
  output logic [PLL_COUNT-1:0][WORDS_PER_PLL-1:0][HALF_W-1:0] conWord,
  output logic [HALF_W-1:0] modeWord,
  output logic [BUS_W-1:0]  rdData
);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < PLL_COUNT; p++) begin
        for (int w = 0; w < WORDS_PER_PLL; w++) begin
          conWord[p][w] <= (w == WORDS_PER_PLL - 1) ? CTL_WORD_RESET : '0;
        end
      end
    end else if (stb.wrStb && stb.conHit) begin
      conWord[stb.pllSel][stb.wordSel] <=
        maskMerge(conWord[stb.pllSel][stb.wordSel], busWrData);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      modeWord <= '0;
    end else if (stb.wrStb && stb.modeHit) begin
      modeWord <= maskMerge(modeWord, busWrData);
    end
  end

  always_comb begin
    rdData = '0;
    if (stb.conHit) begin
      rdData = {{HALF_W{1'b0}}, conWord[stb.pllSel][stb.wordSel]};
    end else if (stb.modeHit) begin
      rdData = {{HALF_W{1'b0}}, modeWord};
    end
  end

  // R1
  masked_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (stb.wrStb && stb.conHit) |=>
      (((conWord[$past(stb.pllSel)][$past(stb.wordSel)] ^
         $past(conWord[stb.pllSel][stb.wordSel])) &
        ~$past(busWrData[BUS_W-1:HALF_W])) == '0));

  // R4
  unmapped_write_chk: assert property (@(posedge clk) disable iff (rst)
    (stb.wrStb && !stb.conHit && !stb.modeHit) |=>
      ($stable(conWord) && $stable(modeWord)));

  // R4
  unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
    (!stb.conHit && !stb.modeHit) |-> (rdData == '0));

  // R5
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (modeWord == '0 &&
                    conWord[0][WORDS_PER_PLL-1] == CTL_WORD_RESET &&
                    conWord[PLL_COUNT-1][0] == '0));

endmodule

// File: rtl/pll_chan.sv
module pll_chan
  import pll_bank_pkg::*;
#(
  parameter int PARENT_W = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic [HALF_W-1:0] divWord,
  input  logic [HALF_W-1:0] fbWord,
  input  logic [HALF_W-1:0] bwWord,
  input  logic [HALF_W-1:0] ctlWord,
  input  logic [MODE_STRIDE-1:0] modeNib,
  input  logic [PARENT_W-1:0] parentRate,
  output logic [DIV_W-1:0] refDiv,
  output logic [DIV_W-1:0] outDiv,
  output logic [FB_W-1:0] fbMul,
  output logic [BW_W-1:0] bwAdj,
  output logic [MODE_FLD_W-1:0] mode,
  output logic bypass,
  output logic powerDown,
  output logic standby,
  output logic pllRst,
  output logic normal,
  output logic [PARENT_W+FB_W-1:0] rate
);

  localparam int RATE_W = PARENT_W + FB_W;

  logic unusedBits;
  assign unusedBits = ^{divWord[HALF_W-1:REF_LSB+DIV_W], divWord[REF_LSB-1:OD_LSB+DIV_W],
                        bwWord[HALF_W-1:BW_W], ctlWord[HALF_W-1:RST_BIT+1],
                        ctlWord[RST_BIT-1:SB_BIT+1], modeNib[MODE_STRIDE-1:MODE_FLD_W]};

  assign outDiv    = divWord[OD_LSB +: DIV_W];
  assign refDiv    = divWord[REF_LSB +: DIV_W];
  assign fbMul     = fbWord[FB_W-1:0];
  assign bwAdj     = bwWord[BW_W-1:0];
  assign bypass    = ctlWord[BYP_BIT];
  assign powerDown = ctlWord[PD_BIT];
  assign standby   = ctlWord[SB_BIT];
  assign pllRst    = ctlWord[RST_BIT];
  assign mode      = modeNib[MODE_FLD_W-1:0];
  assign normal    = (mode == MODE_NORMAL) && !bypass;

  logic [CALC_W-1:0] product, afterRef, afterOut;

  always_comb begin
    product  = CALC_W'(parentRate) * (CALC_W'(fbMul) + CALC_W'(1));
    afterRef = product / (CALC_W'(refDiv) + CALC_W'(1));
    afterOut = afterRef / (CALC_W'(outDiv) + CALC_W'(1));
    rate     = normal ? RATE_W'(afterOut) : RATE_W'(parentRate);
  end

  // R12
  fallback_rate_chk: assert property (@(posedge clk) disable iff (rst)
    !normal |-> (rate == RATE_W'(parentRate)));

  // R11
  rate_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (normal && fbMul == '0) |-> (rate <= RATE_W'(parentRate)));

endmodule

// File: rtl/pll_ctrl_bank.sv
module pll_ctrl_bank
  import pll_bank_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int PARENT_W = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic busWrEn,
  input  logic [31:0] busWrData,
  output logic [31:0] busRdData,
  input  logic [PARENT_W-1:0] parentRate,
  output logic [3:0][5:0] pllRefDiv,
  output logic [3:0][5:0] pllOutDiv,
  output logic [3:0][15:0] pllFbMul,
  output logic [3:0][11:0] pllBwAdj,
  output logic [3:0][1:0] pllMode,
  output logic [3:0] pllBypass,
  output logic [3:0] pllPowerDown,
  output logic [3:0] pllStandby,
  output logic [3:0] pllReset,
  output logic [3:0] pllNormal,
  output logic [3:0][PARENT_W+15:0] pllRate
);

  bankStrobe_t stb;
  logic [PLL_COUNT-1:0][WORDS_PER_PLL-1:0][HALF_W-1:0] conWord;
  logic [HALF_W-1:0] modeWord;

  pll_bank_decode #(.ADDR_W(ADDR_W)) uDecode (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .stb     (stb)
  );

  pll_bank_regs uRegs (
    .clk       (clk),
    .rst       (rst),
    .stb       (stb),
    .busWrData (busWrData),
    .conWord   (conWord),
    .modeWord  (modeWord),
    .rdData    (busRdData)
  );

  for (genvar p = 0; p < PLL_COUNT; p++) begin : gChan
    pll_chan #(.PARENT_W(PARENT_W)) uChan (
      .clk        (clk),
      .rst        (rst),
      .divWord    (conWord[p][0]),
      .fbWord     (conWord[p][1]),
      .bwWord     (conWord[p][2]),
      .ctlWord    (conWord[p][3]),
      .modeNib    (modeWord[p*MODE_STRIDE +: MODE_STRIDE]),
      .parentRate (parentRate),
      .refDiv     (pllRefDiv[p]),
      .outDiv     (pllOutDiv[p]),
      .fbMul      (pllFbMul[p]),
      .bwAdj      (pllBwAdj[p]),
      .mode       (pllMode[p]),
      .bypass     (pllBypass[p]),
      .powerDown  (pllPowerDown[p]),
      .standby    (pllStandby[p]),
      .pllRst     (pllReset[p]),
      .normal     (pllNormal[p]),
      .rate       (pllRate[p])
    );
  end

endmodule

// File: tb/sim_pll_ctrl_bank.sv
module sim_pll_ctrl_bank;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst;
  logic [7:0] busAddr;
  logic busWrEn;
  logic [31:0] busWrData;
  logic [31:0] busRdData;
  logic [31:0] parentRate;
  logic [3:0][5:0] pllRefDiv, pllOutDiv;
  logic [3:0][15:0] pllFbMul;
  logic [3:0][11:0] pllBwAdj;
  logic [3:0][1:0] pllMode;
  logic [3:0] pllBypass, pllPowerDown, pllStandby, pllReset, pllNormal;
  logic [3:0][47:0] pllRate;

  pll_ctrl_bank u0 (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .parentRate(parentRate),
    .pllRefDiv(pllRefDiv), .pllOutDiv(pllOutDiv), .pllFbMul(pllFbMul),
    .pllBwAdj(pllBwAdj), .pllMode(pllMode), .pllBypass(pllBypass),
    .pllPowerDown(pllPowerDown), .pllStandby(pllStandby), .pllReset(pllReset),
    .pllNormal(pllNormal), .pllRate(pllRate)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  logic [15:0] mCon [4][4];
  logic [15:0] mMode;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int p = 0; p < 4; p++)
      for (int w = 0; w < 4; w++)
        mCon[p][w] = (w == 3) ? 16'h0001 : 16'h0000;
    mMode = 16'h0000;
  endtask

  function automatic logic [15:0] merge(input logic [15:0] cur, input logic [31:0] d);
    return (cur & ~d[31:16]) | (d[15:0] & d[31:16]);
  endfunction

  function automatic logic [31:0] expRead(input logic [7:0] a);
    if (a[1:0] == 2'b00 && a < 8'd64) return {16'h0, mCon[a[5:4]][a[3:2]]};
    if (a == 8'd64) return {16'h0, mMode};
    return 32'h0;
  endfunction

  function automatic bit expNormal(input int p);
    return (mMode[p*4 +: 2] == 2'd1) && !mCon[p][3][0];
  endfunction

  function automatic logic [47:0] expRate(input int p);
    longint unsigned v;
    if (!expNormal(p)) return 48'(parentRate);
    v = longint'(parentRate) * (longint'(mCon[p][1]) + 1);
    v = v / (longint'(mCon[p][0][13:8]) + 1);
    v = v / (longint'(mCon[p][0][5:0]) + 1);
    return 48'(v);
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
    if (a[1:0] == 2'b00 && a < 8'd64) mCon[a[5:4]][a[3:2]] = merge(mCon[a[5:4]][a[3:2]], d);
    else if (a == 8'd64) mMode = merge(mMode, d);
  endtask

  task automatic rdChk(input logic [7:0] a, input string tag);
    busAddr = a;
    #1;
    chk(busRdData == expRead(a), tag, 64'(busRdData), 64'(expRead(a)));
  endtask

  task automatic outChk();
    for (int p = 0; p < 4; p++) begin
      chk(pllOutDiv[p] == mCon[p][0][5:0], "R6 outDiv", 64'(pllOutDiv[p]), 64'(mCon[p][0][5:0]));
      chk(pllRefDiv[p] == mCon[p][0][13:8], "R6 refDiv", 64'(pllRefDiv[p]), 64'(mCon[p][0][13:8]));
      chk(pllFbMul[p] == mCon[p][1], "R7 fbMul", 64'(pllFbMul[p]), 64'(mCon[p][1]));
      chk(pllBwAdj[p] == mCon[p][2][11:0], "R7 bwAdj", 64'(pllBwAdj[p]), 64'(mCon[p][2][11:0]));
      chk({pllReset[p], pllStandby[p], pllPowerDown[p], pllBypass[p]} ==
          {mCon[p][3][5], mCon[p][3][2:0]}, "R8 controls",
          64'({pllReset[p], pllStandby[p], pllPowerDown[p], pllBypass[p]}),
          64'({mCon[p][3][5], mCon[p][3][2:0]}));
      chk(pllMode[p] == mMode[p*4 +: 2], "R9 mode", 64'(pllMode[p]), 64'(mMode[p*4 +: 2]));
      chk(pllNormal[p] == expNormal(p), "R10 normal", 64'(pllNormal[p]), 64'(expNormal(p)));
      if (expNormal(p))
        chk(pllRate[p] == expRate(p), "R11 rate", 64'(pllRate[p]), 64'(expRate(p)));
      else
        chk(pllRate[p] == expRate(p), "R12 rate", 64'(pllRate[p]), 64'(expRate(p)));
    end
  endtask

  task automatic allChk(input string tag);
    for (int p = 0; p < 4; p++)
      for (int w = 0; w < 4; w++)
        rdChk(8'(p * 16 + w * 4), tag);
    rdChk(8'd64, tag);
    outChk();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] a;
    void'($urandom(32'd7351));
    rst = 1'b1; busWrEn = 1'b0; busAddr = '0; busWrData = '0;
    parentRate = 32'd24000000;
    modelReset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R5 reset state
    allChk("R5 reset R3");

    // R1 masked partial updates on loop 1 word 0 (address 0x10, R2)
    wr(8'h10, 32'hFFFF_1234);
    rdChk(8'h10, "R1 R2 full mask");
    wr(8'h10, 32'h00FF_ABCD);
    chk(busRdData == 32'h0000_12CD, "R1 low byte only", 64'(busRdData), 64'h12CD);
    wr(8'h10, 32'h0000_FFFF);
    chk(busRdData == 32'h0000_12CD, "R1 zero mask", 64'(busRdData), 64'h12CD);

    // R4 unmapped and misaligned writes change nothing and read zero
    wr(8'h44, 32'hFFFF_FFFF);
    wr(8'h42, 32'hFFFF_FFFF);
    wr(8'h12, 32'hFFFF_FFFF);
    wr(8'hFC, 32'hFFFF_FFFF);
    allChk("R4 after unmapped writes");
    rdChk(8'h44, "R4 read 0x44");
    rdChk(8'h12, "R4 read misaligned");
    rdChk(8'hFC, "R4 read 0xFC");

    // R11 directed rates
    wr(8'h00, 32'hFFFF_0000);
    wr(8'h04, 32'hFFFF_0000 | 32'd49);
    wr(8'h0C, 32'h0001_0000);
    wr(8'h40, 32'h0003_0001);
    #1;
    chk(pllRate[0] == 48'd1200000000, "R11 1200M", 64'(pllRate[0]), 64'd1200000000);
    wr(8'h30, 32'hFFFF_0701);
    wr(8'h34, 32'hFFFF_0000 | 32'd593);
    wr(8'h3C, 32'h0001_0000);
    wr(8'h40, 32'h3000_1000);
    #1;
    chk(pllRate[3] == 48'd891000000, "R11 891M", 64'(pllRate[3]), 64'd891000000);
    chk(pllNormal[3] == 1'b1, "R10 loop3 normal", 64'(pllNormal[3]), 64'd1);

    // R12 deep slow and bypass fall back to parent
    wr(8'h40, 32'h3000_2000);
    #1;
    chk(pllRate[3] == 48'd24000000, "R12 deep slow", 64'(pllRate[3]), 64'd24000000);
    wr(8'h0C, 32'h0001_0001);
    #1;
    chk(pllRate[0] == 48'd24000000, "R12 bypass", 64'(pllRate[0]), 64'd24000000);
    chk(pllNormal[0] == 1'b0, "R10 bypass clears normal", 64'(pllNormal[0]), 64'd0);

    // R11 largest fields and parent
    parentRate = 32'hFFFF_FFFF;
    wr(8'h20, 32'hFFFF_3F3F);
    wr(8'h24, 32'hFFFF_FFFF);
    wr(8'h2C, 32'hFFFF_0000);
    wr(8'h40, 32'h0300_0100);
    #1;
    chk(pllRate[2] == 48'hF_FFFF_FFF0, "R11 max fields", 64'(pllRate[2]), 64'hF_FFFF_FFF0);
    allChk("R2 R3 directed sweep");

    // random mix
    for (int it = 0; it < 1500; it++) begin
      case ($urandom % 8)
        0, 1, 2, 3, 4, 5: a = 8'({$urandom % 4, $urandom % 4, 2'b00});
        6: a = 8'd64;
        default: a = 8'($urandom);
      endcase
      parentRate = $urandom;
      wr(a, $urandom);
      #1;
      allChk("R1 R2 R3 R4 random");
      if (a != 8'd64 && !(a[1:0] == 2'b00 && a < 8'd64)) rdChk(a, "R4 random unmapped");
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule